// File: doc/BRIEF.md
# Inversion-Coded Write Encoder

This block prepares one write unit for a non-volatile cell array whose cells are costly to program. The unit is a data word plus one polarity cell that records whether the word is stored inverted. The write is handled as read-modify-write. The caller presents the new data together with the raw cell contents already stored: the old word and the old polarity cell. The block counts how many of those cells would change if the data were stored as-is. When that count exceeds half the data width, it stores the complement instead and sets the polarity cell.

The result is registered one cycle after an input strobe. It has four parts:

- the word to store;
- the new polarity bit;
- a mask of cells that must be driven from 1 to 0;
- a mask of cells that must be driven from 0 to 1.

A count of programmed cells comes with it. Both masks cover the polarity cell as well as the data cells, so the downstream programming logic treats the polarity bit like any other cell. A combinational read-path decoder, also inside the block, restores true data from a stored word and its polarity bit.

Top module: `flip_write_encoder`

## Requirements
- R1: The difference count is the number of positions where the cell image {new_data, 0} differs from {old_data, old_flip}. This count ranges over W+1 cells. When the count is greater than W/2, enc_flip is 1.
- R2: When the difference count equals W/2 exactly, the data is not inverted and enc_flip is 0.
- R3: enc_data equals ~new_data when enc_flip is 1, and equals new_data when enc_flip is 0.
- R4: clr_mask bit i is 1 exactly when the stored cell is 1 and the encoded cell is 0. Bit 0 of the mask is the polarity cell, and bits W:1 are data bits 0 to W-1.
- R5: set_mask uses the same bit layout as clr_mask. Its bit i is 1 exactly when the stored cell is 0 and the encoded cell is 1, so the two masks never overlap. Cells that keep their value are 0 in both masks.
- R6: prog_count equals the number of ones in clr_mask and set_mask together, and it never exceeds W/2.
- R7: rd_data equals rd_word with every bit inverted when rd_flip is 1, and equals rd_word when rd_flip is 0. Applied to enc_data and enc_flip, it returns new_data.
- R8: out_valid rises in the cycle after a cycle with in_valid high. When in_valid is low, out_valid is low on the next cycle and the encoded outputs keep their last values.
- R9: While rst_n is low, out_valid, enc_data, enc_flip, both masks and prog_count are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Write request strobe; inputs are captured when high |
| new_data | input | W | Data to be written |
| old_data | input | W | Word currently stored in the cells |
| old_flip | input | 1 | Polarity cell currently stored |
| out_valid | output | 1 | Encoded result valid |
| enc_data | output | W | Word to program into the cells |
| enc_flip | output | 1 | Polarity bit to program |
| clr_mask | output | W+1 | Cells to drive 1 to 0 (bit 0 = polarity cell) |
| set_mask | output | W+1 | Cells to drive 0 to 1 (bit 0 = polarity cell) |
| prog_count | output | $clog2(W+2) | Number of cells that change |
| rd_word | input | W | Stored word on the read path |
| rd_flip | input | 1 | Stored polarity bit on the read path |
| rd_data | output | W | Decoded true data |

## Verification
The hardest case to reach is a tie in which the polarity cell itself supplies the deciding count. Here the data bits differ in W/2-1 positions and the old polarity cell is 1, so the total sits exactly at W/2 and the word must not be inverted. Random words almost never land on this boundary. The stimulus therefore builds old words by XOR-ing new data with a mask of a chosen number of ones, sweeping counts around W/2 with both old polarity values. Dense random traffic and back-to-back requests then check the masks, the count and the read-path round trip.

// File: rtl/fwe_pkg.sv
`timescale 1ns/1ps
package fwe_pkg;
  typedef enum logic {
    POL_KEEP   = 1'b0,
    POL_INVERT = 1'b1
  } polarity_e;
endpackage

// File: rtl/fwe_popcount.sv
`timescale 1ns/1ps
module fwe_popcount #(
  parameter int N  = 65,
  parameter int CW = $clog2(N + 1)
) (
  input  logic [N-1:0]  vec,
  output logic [CW-1:0] cnt
);
  always_comb begin
    cnt = '0;
    for (int i = 0; i < N; i++) begin
      cnt = cnt + CW'(vec[i]);
    end
  end
endmodule

// File: rtl/fwe_decide.sv
`timescale 1ns/1ps
module fwe_decide
  import fwe_pkg::*;
#(
  parameter int W  = 64,
  parameter int CW = $clog2(W + 2)
) (
  input  logic [W-1:0]  new_data,
  input  logic [W-1:0]  old_data,
  input  logic          old_flip,
  output polarity_e     pol,
  output logic [W-1:0]  cand_data,
  output logic [W:0]    cand_clr,
  output logic [W:0]    cand_set,
  output logic [CW-1:0] cand_count
);
  localparam int HALF = W / 2;
  localparam int NC   = W + 1;

  logic [NC-1:0] cur_cells;
  logic [NC-1:0] plain_cells;
  logic [NC-1:0] nxt_cells;
  logic [CW-1:0] diff_cnt;

  assign cur_cells   = {old_data, old_flip};
  assign plain_cells = {new_data, 1'b0};

  fwe_popcount #(.N(NC), .CW(CW)) u_diff (
    .vec (cur_cells ^ plain_cells),
    .cnt (diff_cnt)
  );

  always_comb begin
    pol = (diff_cnt > CW'(HALF)) ? POL_INVERT : POL_KEEP;
    if (pol == POL_INVERT) begin
      cand_data  = ~new_data;
      cand_count = CW'(NC) - diff_cnt;
    end else begin
      cand_data  = new_data;
      cand_count = diff_cnt;
    end
    nxt_cells = {cand_data, (pol == POL_INVERT)};
    cand_clr  = cur_cells & ~nxt_cells;
    cand_set  = ~cur_cells & nxt_cells;
  end
endmodule

// File: rtl/fwe_read_decoder.sv
`timescale 1ns/1ps
module fwe_read_decoder #(
  parameter int W = 64
) (
  input  logic [W-1:0] rd_word,
  input  logic         rd_flip,
  output logic [W-1:0] rd_data
);
  assign rd_data = rd_word ^ {W{rd_flip}};
endmodule

// File: rtl/flip_write_encoder.sv
`timescale 1ns/1ps
module flip_write_encoder
  import fwe_pkg::*;
#(
  parameter int W  = 64,
  parameter int CW = $clog2(W + 2)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [W-1:0]  new_data,
  input  logic [W-1:0]  old_data,
  input  logic          old_flip,
  output logic          out_valid,
  output logic [W-1:0]  enc_data,
  output logic          enc_flip,
  output logic [W:0]    clr_mask,
  output logic [W:0]    set_mask,
  output logic [CW-1:0] prog_count,
  input  logic [W-1:0]  rd_word,
  input  logic          rd_flip,
  output logic [W-1:0]  rd_data
);
  localparam int HALF = W / 2;

  polarity_e     pol;
  logic [W-1:0]  cand_data;
  logic [W:0]    cand_clr, cand_set;
  logic [CW-1:0] cand_count;

  fwe_decide #(.W(W), .CW(CW)) u_decide (
    .new_data   (new_data),
    .old_data   (old_data),
    .old_flip   (old_flip),
    .pol        (pol),
    .cand_data  (cand_data),
    .cand_clr   (cand_clr),
    .cand_set   (cand_set),
    .cand_count (cand_count)
  );

  fwe_read_decoder #(.W(W)) u_rd (
    .rd_word (rd_word),
    .rd_flip (rd_flip),
    .rd_data (rd_data)
  );

  logic          valid_q, valid_d;
  logic [W-1:0]  data_q, data_d;
  logic          flip_q, flip_d;
  logic [W:0]    clr_q, clr_d, set_q, set_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    valid_d = in_valid;
    data_d  = data_q;
    flip_d  = flip_q;
    clr_d   = clr_q;
    set_d   = set_q;
    cnt_d   = cnt_q;
    if (in_valid) begin
      data_d = cand_data;
      flip_d = (pol == POL_INVERT);
      clr_d  = cand_clr;
      set_d  = cand_set;
      cnt_d  = cand_count;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
      flip_q  <= 1'b0;
      clr_q   <= '0;
      set_q   <= '0;
      cnt_q   <= '0;
    end else begin
      valid_q <= valid_d;
      data_q  <= data_d;
      flip_q  <= flip_d;
      clr_q   <= clr_d;
      set_q   <= set_d;
      cnt_q   <= cnt_d;
    end
  end

  assign out_valid  = valid_q;
  assign enc_data   = data_q;
  assign enc_flip   = flip_q;
  assign clr_mask   = clr_q;
  assign set_mask   = set_q;
  assign prog_count = cnt_q;

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);                                                  // R8
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(enc_data) && $stable(enc_flip)));    // R8
  AST_MASKS_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((clr_mask & set_mask) == '0));                             // R5
  AST_COUNT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($countones(clr_mask | set_mask) == int'(prog_count)));     // R6
  AST_PROG_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (int'(prog_count) <= HALF));                                // R6
  AST_SET_POL_CELL: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && set_mask[0]) |-> enc_flip);                                 // R4
  AST_CLR_POL_CELL: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && clr_mask[0]) |-> !enc_flip);                                // R4
endmodule

// File: tb/sim_flip_write_encoder.sv
`timescale 1ns/1ps
module sim_flip_write_encoder;
  localparam int W  = 64;
  localparam int CW = $clog2(W + 2);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid;
  logic [W-1:0]  new_data, old_data;
  logic          old_flip;
  logic          out_valid;
  logic [W-1:0]  enc_data;
  logic          enc_flip;
  logic [W:0]    clr_mask, set_mask;
  logic [CW-1:0] prog_count;
  logic [W-1:0]  rd_word;
  logic          rd_flip;
  logic [W-1:0]  rd_data;

  always #5 clk = ~clk;

  flip_write_encoder #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .new_data(new_data), .old_data(old_data), .old_flip(old_flip),
    .out_valid(out_valid), .enc_data(enc_data), .enc_flip(enc_flip),
    .clr_mask(clr_mask), .set_mask(set_mask), .prog_count(prog_count),
    .rd_word(rd_word), .rd_flip(rd_flip), .rd_data(rd_data)
  );

  typedef struct {
    logic [W-1:0] nd;
    logic [W-1:0] d;
    logic         f;
    logic [W:0]   c;
    logic [W:0]   s;
    int           n;
    string        tag;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   fails  = 0;
  bit   have_last = 0;
  exp_t last;
  bit   done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic exp_t model(input logic [W-1:0] nw, input logic [W-1:0] od,
                                 input logic of);
    exp_t e;
    int diff = 0;
    logic [W:0] cur, nxt;
    for (int i = 0; i < W; i++) diff += int'(nw[i] ^ od[i]);
    diff += int'(of);
    e.nd  = nw;
    e.f   = (diff > W / 2);
    e.d   = e.f ? ~nw : nw;
    e.tag = (diff == W / 2) ? "R2" : "R1";
    cur = {od, of};
    nxt = {e.d, e.f};
    e.c = cur & ~nxt;
    e.s = ~cur & nxt;
    e.n = 0;
    for (int i = 0; i <= W; i++) e.n += int'(e.c[i] | e.s[i]);
    return e;
  endfunction

  function automatic logic [W-1:0] ones_low(input int k);
    logic [W-1:0] m = '0;
    for (int i = 0; i < W; i++) if (i < k) m[i] = 1'b1;
    return m;
  endfunction

  task automatic send(input logic [W-1:0] nw, input logic [W-1:0] od, input logic of);
    @(negedge clk);
    in_valid = 1'b1;
    new_data = nw;
    old_data = od;
    old_flip = of;
    q.push_back(model(nw, od, of));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  // Scoreboard monitor
  initial begin
    rd_word = '0;
    rd_flip = 1'b0;
    forever begin
      @(posedge clk);
      #1;
      if (rst_n && out_valid) begin
        exp_t e;
        if (q.size() == 0) begin
          chk(1'b0, "R8", "unexpected out_valid", 128'(out_valid), 128'(0));
        end else begin
          e = q.pop_front();
          chk(enc_flip == e.f, e.tag, "enc_flip", 128'(enc_flip), 128'(e.f));
          chk(enc_data == e.d, "R3", "enc_data", 128'(enc_data), 128'(e.d));
          chk(clr_mask == e.c, "R4", "clr_mask", 128'(clr_mask), 128'(e.c));
          chk(set_mask == e.s, "R5", "set_mask", 128'(set_mask), 128'(e.s));
          chk(int'(prog_count) == e.n && e.n <= W / 2, "R6", "prog_count",
              128'(prog_count), 128'(e.n));
          rd_word = enc_data;
          rd_flip = enc_flip;
          #1;
          chk(rd_data == e.nd, "R7", "decode round trip", 128'(rd_data), 128'(e.nd));
          rd_flip = ~enc_flip;
          #1;
          chk(rd_data == ~e.nd, "R7", "decode opposite polarity", 128'(rd_data), 128'(~e.nd));
          last = e;
          have_last = 1;
        end
      end else if (rst_n && have_last) begin
        chk(enc_data == last.d && enc_flip == last.f, "R8", "hold while idle",
            128'({enc_flip, enc_data}), 128'({last.f, last.d}));
      end
    end
  end

  // Watchdog
  initial begin
    #(10 * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] nw;
    rst_n    = 1'b0;
    in_valid = 1'b0;
    new_data = '0;
    old_data = '0;
    old_flip = 1'b0;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0 && enc_data == '0 && enc_flip == 1'b0 &&
        clr_mask == '0 && set_mask == '0 && prog_count == '0,
        "R9", "reset state", 128'({out_valid, enc_flip, enc_data}), 128'(0));
    rst_n = 1'b1;
    idle(2);

    nw = 64'hA5A5_0F0F_1234_CAFE;
    send(nw, nw, 1'b0);                 // R1: no change at all
    send(nw, nw, 1'b1);                 // R4: only polarity cell clears
    send(nw, ~nw, 1'b0);                // R1: full inversion, only polarity cell sets
    send(nw, ~nw, 1'b1);                // R1: nothing changes
    idle(3);
    send(nw, nw ^ ones_low(W / 2), 1'b0);       // R2: tie on data bits
    send(nw, nw ^ ones_low(W / 2 - 1), 1'b1);   // R2: tie reached through polarity cell
    send(nw, nw ^ ones_low(W / 2 + 1), 1'b0);   // R1: one above half
    send(nw, nw ^ ones_low(W / 2), 1'b1);       // R1: above half via polarity cell
    idle(2);
    for (int k = W / 2 - 3; k <= W / 2 + 3; k++) begin
      send(nw, nw ^ (ones_low(k) << 7), 1'b0);
      send(~nw, ~nw ^ (ones_low(k) << 3), 1'b1);
    end
    idle(2);
    for (int i = 0; i < 300; i++) begin
      logic [W-1:0] a, b;
      a = {$urandom, $urandom};
      b = {$urandom, $urandom};
      send(a, b, 1'($urandom));
      if (($urandom % 5) == 0) idle(1 + $urandom % 3);
    end
    idle(4);
    chk(q.size() == 0, "R8", "all results delivered", 128'(q.size()), 128'(0));
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule